// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a small 32-bit processor that finishes one instruction on every rising clock edge. In one cycle it fetches from a combinational instruction ROM, decodes the instruction, reads two registers, runs the ALU, optionally touches data memory and writes the result back. It supports word load and store, five register-to-register operations (add, subtract, and, or, signed set-less-than), branch-if-equal and an absolute jump.

The program image and the initial data-memory image are passed in as parameters. A synchronous reset clears the program counter and the registers and reloads data memory from its image. The only outputs are debug taps: the current program counter and the write-back bus (enable, destination register, value). An integrating test or a larger design observes execution through these taps.

Top module: `rcore_top`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0, all registers are cleared, data memory word i is loaded from `DMEM_INIT[32*i +: 32]`, and `dbg_wb_en` stays low.
- R2: An instruction that is not a taken branch and not a jump moves the PC to PC+4 at the next edge.
- R3: Opcode 0x04 (bits 31:26) compares register rs (bits 25:21) with register rt (bits 20:16) by subtraction. When they are equal, the next PC is PC+4 plus the sign-extended immediate (bits 15:0) shifted left by 2. Otherwise the next PC is PC+4.
- R4: Opcode 0x02 loads the PC with {PC+4[31:28], bits 25:0 of the instruction, 2'b00}.
- R5: Opcode 0x00 with funct (bits 5:0) 0x20 add, 0x22 sub, 0x24 and, 0x25 or or 0x2A signed set-less-than writes the result of rs op rt to register rd (bits 15:11).
- R6: Opcode 0x23 writes data-memory word (rs + sign-extended offset) to register rt. The word index is address bits [DA_W+1:2].
- R7: Opcode 0x2B writes register rt to data-memory word (rs + sign-extended offset) at the edge and writes no register.
- R8: Register 0 always reads as zero. A write that targets it has no effect and does not raise `dbg_wb_en`.
- R9: An instruction that reads and writes the same register uses the value held before its own write.
- R10: Any other opcode, or opcode 0x00 with any other funct, writes no register and no memory and moves the PC by 4.
- R11: `dbg_wb_en` is high exactly when a nonzero register is written at the coming edge. `dbg_wb_reg` and `dbg_wb_data` then give the register and the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dbg_pc | output | 32 | Byte address of the instruction executing this cycle |
| dbg_wb_en | output | 1 | A nonzero register is written at the coming edge |
| dbg_wb_reg | output | 5 | Register being written |
| dbg_wb_data | output | 32 | Value being written |

## Verification
The bench builds the core with a 32-word program ROM and a 16-word data memory. Both images are computed in the bench: the program from encoding functions, the data from four seed words that include a negative value and a mixed bit pattern. These sizes are enough for a program that loads seeds, uses every ALU operation, writes register 0, reuses a register as its own source and destination, stores and reloads a word, and uses a negative load offset. The same program runs not-taken, forward-taken and backward-taken branches, a jump, and undefined opcode and funct values. The program ends in a self-loop, and the PC trace is checked for every cycle.

// File: rtl/rcore_pkg.sv
package rcore_pkg;
    localparam logic [5:0] OPC_ALU   = 6'h00;
    localparam logic [5:0] OPC_JMP   = 6'h02;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic    reg_write;
        logic    dst_rd;
        logic    alu_imm;
        logic    mem_to_reg;
        logic    mem_write;
        logic    branch;
        logic    jump;
        alu_op_e alu_op;
    } ctrl_t;
endpackage

// File: rtl/rcore_alu.sv
module rcore_alu
    import rcore_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        unique case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/rcore_decode.sv
module rcore_decode
    import rcore_pkg::*;
(
    input  logic [31:0] instr,
    output ctrl_t       ctrl
);
    logic [5:0] opc;
    logic [5:0] fn;

    assign opc = instr[31:26];
    assign fn  = instr[5:0];

    always_comb begin
        ctrl = '{reg_write: 1'b0, dst_rd: 1'b0, alu_imm: 1'b0, mem_to_reg: 1'b0,
                 mem_write: 1'b0, branch: 1'b0, jump: 1'b0, alu_op: ALU_ADD};
        unique case (opc)
            OPC_ALU: begin
                ctrl.dst_rd = 1'b1;
                ctrl.reg_write = 1'b1;
                unique case (fn)
                    FN_ADD:  ctrl.alu_op = ALU_ADD;
                    FN_SUB:  ctrl.alu_op = ALU_SUB;
                    FN_AND:  ctrl.alu_op = ALU_AND;
                    FN_OR:   ctrl.alu_op = ALU_OR;
                    FN_SLT:  ctrl.alu_op = ALU_SLT;
                    default: ctrl.reg_write = 1'b0;
                endcase
            end
            OPC_LOAD: begin
                ctrl.reg_write  = 1'b1;
                ctrl.alu_imm    = 1'b1;
                ctrl.mem_to_reg = 1'b1;
            end
            OPC_STORE: begin
                ctrl.alu_imm   = 1'b1;
                ctrl.mem_write = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            OPC_JMP: ctrl.jump = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/rcore_regfile.sv
module rcore_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);
    logic [NREG-1:0][W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we && waddr != '0) regs_d[waddr] = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '0;
        else     regs_q <= regs_d;
    end

    assign rdata_a = (raddr_a == '0) ? '0 : regs_q[raddr_a];
    assign rdata_b = (raddr_b == '0) ? '0 : regs_q[raddr_b];
endmodule

// File: rtl/rcore_top.sv
module rcore_top
    import rcore_pkg::*;
#(
    parameter int IMEM_WORDS = 32,
    parameter int DMEM_WORDS = 16,
    parameter logic [IMEM_WORDS*32-1:0] PROG      = '0,
    parameter logic [DMEM_WORDS*32-1:0] DMEM_INIT = '0
) (
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] dbg_pc,
    output logic        dbg_wb_en,
    output logic [4:0]  dbg_wb_reg,
    output logic [31:0] dbg_wb_data
);
    localparam int IA_W = $clog2(IMEM_WORDS);
    localparam int DA_W = $clog2(DMEM_WORDS);

    typedef struct packed {
        logic [31:0]                  pc;
        logic [DMEM_WORDS-1:0][31:0]  mem;
    } state_t;

    state_t      st_d, st_q;
    logic [31:0] instr;
    ctrl_t       ctrl;
    logic [31:0] rs_val, rt_val, sext, alu_b, alu_y, wb_data, rd_word;
    logic [31:0] pc_plus4, br_target, jmp_target;
    logic [4:0]  dest;
    logic [DA_W-1:0] daddr;
    logic        alu_zero, rf_we;

    assign instr = PROG[32*st_q.pc[IA_W+1:2] +: 32];

    rcore_decode u_dec (.instr(instr), .ctrl(ctrl));

    assign dest  = ctrl.dst_rd ? instr[15:11] : instr[20:16];
    assign rf_we = ctrl.reg_write && !rst;

    rcore_regfile #(.NREG(32), .W(32)) u_rf (
        .clk(clk), .rst(rst), .we(rf_we), .waddr(dest), .wdata(wb_data),
        .raddr_a(instr[25:21]), .raddr_b(instr[20:16]),
        .rdata_a(rs_val), .rdata_b(rt_val)
    );

    assign sext  = {{16{instr[15]}}, instr[15:0]};
    assign alu_b = ctrl.alu_imm ? sext : rt_val;

    rcore_alu #(.W(32)) u_alu (
        .a(rs_val), .b(alu_b), .op(ctrl.alu_op), .y(alu_y), .zero(alu_zero)
    );

    assign daddr   = alu_y[DA_W+1:2];
    assign rd_word = st_q.mem[daddr];
    assign wb_data = ctrl.mem_to_reg ? rd_word : alu_y;

    assign pc_plus4   = st_q.pc + 32'd4;
    assign br_target  = pc_plus4 + {sext[29:0], 2'b00};
    assign jmp_target = {pc_plus4[31:28], instr[25:0], 2'b00};

    always_comb begin
        st_d = st_q;
        if (ctrl.jump)                     st_d.pc = jmp_target;
        else if (ctrl.branch && alu_zero)  st_d.pc = br_target;
        else                               st_d.pc = pc_plus4;
        if (ctrl.mem_write) st_d.mem[daddr] = rt_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.pc  <= '0;
            st_q.mem <= DMEM_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign dbg_pc      = st_q.pc;
    assign dbg_wb_en   = rf_we && (dest != 5'd0);
    assign dbg_wb_reg  = dest;
    assign dbg_wb_data = wb_data;
endmodule

// File: rtl/rcore_chk.sv
module rcore_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc,
    input logic [31:0] instr,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic        wb_en,
    input logic [4:0]  wb_reg
);
    logic [5:0] opc;
    logic       known;
    assign opc   = instr[31:26];
    assign known = (opc == 6'h00) || (opc == 6'h02) || (opc == 6'h04) ||
                   (opc == 6'h23) || (opc == 6'h2B);

    AST_RESET_PC: assert property (@(posedge clk) rst |=> (pc == 32'd0)); // R1

    AST_RESET_QUIET: assert property (@(posedge clk) rst |-> !wb_en); // R1

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (opc != 6'h02 && opc != 6'h04) |=> (pc == $past(pc) + 32'd4)); // R2

    AST_BEQ_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (opc == 6'h04 && rs_val == rt_val)
        |=> (pc == $past(pc + 32'd4 + {{14{instr[15]}}, instr[15:0], 2'b00}))); // R3

    AST_BEQ_FALL: assert property (@(posedge clk) disable iff (rst)
        (opc == 6'h04 && rs_val != rt_val) |=> (pc == $past(pc) + 32'd4)); // R3

    AST_JUMP_TGT: assert property (@(posedge clk) disable iff (rst)
        (opc == 6'h02)
        |=> (pc == $past({pc[31:28] + {3'b000, (pc[27:0] > 28'hFFFFFFB)}, instr[25:0], 2'b00}))); // R4

    AST_ZERO_REG: assert property (@(posedge clk) disable iff (rst)
        (instr[25:21] == 5'd0) |-> (rs_val == 32'd0)); // R8

    AST_NO_WB_R0: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (wb_reg != 5'd0)); // R8

    AST_STORE_NOWB: assert property (@(posedge clk) disable iff (rst)
        (opc == 6'h2B || opc == 6'h04 || opc == 6'h02) |-> !wb_en); // R7

    AST_UNKNOWN_NOWB: assert property (@(posedge clk) disable iff (rst)
        !known |-> !wb_en); // R10
endmodule

bind rcore_top rcore_chk u_chk (
    .clk(clk), .rst(rst), .pc(dbg_pc), .instr(instr),
    .rs_val(rs_val), .rt_val(rt_val), .wb_en(dbg_wb_en), .wb_reg(dbg_wb_reg)
);

// File: tb/rcore_top_test.sv
`timescale 1ns/1ps
module rcore_top_test;
    localparam int IMW = 32;
    localparam int DMW = 16;

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        return {op, rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    function automatic logic [IMW*32-1:0] mk_prog();
        logic [IMW*32-1:0] p;
        p = '0;
        p[32*0  +: 32] = enc_i(6'h23, 0, 1, 0);      // lw r1,0(r0)
        p[32*1  +: 32] = enc_i(6'h23, 0, 2, 4);      // lw r2,4(r0)
        p[32*2  +: 32] = enc_i(6'h23, 0, 3, 8);      // lw r3,8(r0)
        p[32*3  +: 32] = enc_r(1, 2, 4, 6'h20);      // add
        p[32*4  +: 32] = enc_r(1, 2, 5, 6'h22);      // sub
        p[32*5  +: 32] = enc_r(4, 2, 6, 6'h24);      // and
        p[32*6  +: 32] = enc_r(1, 2, 7, 6'h25);      // or
        p[32*7  +: 32] = enc_r(3, 1, 8, 6'h2A);      // slt -3<5
        p[32*8  +: 32] = enc_r(1, 3, 9, 6'h2A);      // slt 5<-3
        p[32*9  +: 32] = enc_r(1, 2, 0, 6'h20);      // write r0
        p[32*10 +: 32] = enc_r(0, 1, 10, 6'h20);     // r10 = r0 + r1
        p[32*11 +: 32] = enc_r(1, 1, 1, 6'h20);      // r1 = r1 + r1
        p[32*12 +: 32] = enc_i(6'h2B, 0, 4, 12);     // sw r4,12(r0)
        p[32*13 +: 32] = enc_i(6'h23, 0, 11, 12);    // lw r11,12(r0)
        p[32*14 +: 32] = enc_i(6'h04, 1, 2, 5);      // beq not taken
        p[32*15 +: 32] = enc_i(6'h04, 4, 11, 1);     // beq taken -> 17
        p[32*16 +: 32] = enc_r(1, 1, 12, 6'h20);     // skipped
        p[32*17 +: 32] = enc_i(6'h3F, 1, 13, 0);     // undefined opcode
        p[32*18 +: 32] = enc_r(1, 2, 13, 6'h03);     // undefined funct
        p[32*19 +: 32] = enc_i(6'h23, 4, 12, -8);    // lw r12,-8(r4)
        p[32*20 +: 32] = {6'h02, 26'd23};            // j 23
        p[32*21 +: 32] = enc_r(1, 1, 13, 6'h20);     // skipped
        p[32*22 +: 32] = enc_r(1, 1, 14, 6'h20);     // skipped
        p[32*23 +: 32] = enc_i(6'h04, 0, 0, -1);     // self loop
        return p;
    endfunction

    function automatic logic [DMW*32-1:0] mk_data();
        logic [DMW*32-1:0] d;
        d = '0;
        d[32*0 +: 32] = 32'd5;
        d[32*1 +: 32] = 32'd7;
        d[32*2 +: 32] = 32'hFFFF_FFFD;
        d[32*3 +: 32] = 32'h0F0F_00FF;
        return d;
    endfunction

    localparam logic [IMW*32-1:0] PROG = mk_prog();
    localparam logic [DMW*32-1:0] DATA = mk_data();

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] dbg_pc, dbg_wb_data;
    logic        dbg_wb_en;
    logic [4:0]  dbg_wb_reg;

    always #2.5 clk = ~clk;

    rcore_top #(.IMEM_WORDS(IMW), .DMEM_WORDS(DMW), .PROG(PROG), .DMEM_INIT(DATA)) uut (
        .clk(clk), .rst(rst), .dbg_pc(dbg_pc), .dbg_wb_en(dbg_wb_en),
        .dbg_wb_reg(dbg_wb_reg), .dbg_wb_data(dbg_wb_data)
    );

    typedef struct { logic [4:0] r; logic [31:0] v; string tag; } wb_item_t;
    wb_item_t exp_q[$];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic push_wb(int r, logic [31:0] v, string tag);
        wb_item_t it;
        it.r = r[4:0]; it.v = v; it.tag = tag;
        exp_q.push_back(it);
    endtask

    function automatic int pc_word(int k);
        if (k <= 15) return k;
        if (k <= 19) return k + 1;
        return 23;
    endfunction
    function automatic string pc_tag(int k);
        if (k == 15 || k == 16 || k >= 21) return "R3";
        if (k == 20) return "R4";
        if (k == 17 || k == 18) return "R10";
        return "R2";
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // driver: expected write-back stream
    initial begin
        push_wb(1, 32'd5, "R6");
        push_wb(2, 32'd7, "R6");
        push_wb(3, 32'hFFFF_FFFD, "R6");
        push_wb(4, 32'd12, "R5");
        push_wb(5, 32'hFFFF_FFFE, "R5");
        push_wb(6, 32'd4, "R5");
        push_wb(7, 32'd7, "R5");
        push_wb(8, 32'd1, "R5");
        push_wb(9, 32'd0, "R5");
        push_wb(10, 32'd5, "R8");
        push_wb(1, 32'd10, "R9");
        push_wb(11, 32'd12, "R7");
        push_wb(12, 32'd7, "R6");
    end

    // monitor
    initial begin
        wb_item_t it;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(dbg_pc == 32'd0, "R1", "pc in reset", dbg_pc, 32'd0);
        check(!dbg_wb_en, "R1", "wb_en in reset", {31'd0, dbg_wb_en}, 32'd0);
        rst = 1'b0;
        for (int k = 0; k < 40; k++) begin
            #1;
            check(dbg_pc == 32'(pc_word(k) * 4), pc_tag(k), "pc", dbg_pc, 32'(pc_word(k) * 4));
            if (dbg_wb_en) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R11", "unexpected write-back", {27'd0, dbg_wb_reg}, 32'd0);
                end else begin
                    it = exp_q.pop_front();
                    check(dbg_wb_reg == it.r, it.tag, "wb reg", {27'd0, dbg_wb_reg}, {27'd0, it.r});
                    check(dbg_wb_data == it.v, it.tag, "wb data", dbg_wb_data, it.v);
                end
            end
            @(negedge clk);
        end
        check(exp_q.size() == 0, "R11", "write-backs missing", 32'(exp_q.size()), 32'd0);
        done = 1;
        finish_run();
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            check(1'b0, "R2", "watchdog expired", 32'd0, 32'd1);
            finish_run();
        end
    end
endmodule